// File: doc/BRIEF.md
# Masked Event Interrupt Fan-out

This block collects thirteen controller event flags into the upper bits of a 32-bit event word, gates them with a 32-bit software mask, and drives one dedicated interrupt line per flag. Event pulses arrive from the transmit, receive, management and control logic. A simple register port lets software read both words, acknowledge flags by writing ones to the event word, and replace the mask outright.

Two register writes elsewhere in the controller's map also raise flags. A write to the management frame word raises the management-done flag. A write to the transmit control word with its stop request bit set raises the graceful-stop flag at once. The interrupt lines are registered. They follow a fixed line order that does not match bit order, so a downstream interrupt controller sees each event on a pin that does not move.

Top module: `evt_irq_fanout`

## Requirements
- R1: After reset the event word, the mask word and all thirteen interrupt lines are zero.
- R2: A pulse on `evt_pulse[i]` sets event word bit 19+i on the next clock edge. Flag i and its bit are: 0 underrun (19), 1 retry limit (20), 2 late collision (21), 3 bus error (22), 4 management done (23), 5 receive buffer (24), 6 receive frame (25), 7 transmit buffer (26), 8 transmit frame (27), 9 graceful-stop (28), 10 transmit babble (29), 11 receive babble (30), 12 heartbeat (31).
- R3: A write to offset 0x004 clears each event bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A write to offset 0x008 replaces all 32 bits of the mask word, and a read of 0x008 returns it.
- R5: A read of 0x004 returns the event word, and its bits 18 to 0 always read as 0.
- R6: Interrupt line k equals the masked event bit given by this order of event bits for lines 0 to 12: 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. A line changes on the second clock edge after a write or pulse, which is one edge after the event or mask word changes.
- R7: When a pulse and a software clear hit the same flag in the same cycle, the flag stays set.
- R8: Any write to offset 0x040 sets event bit 23, whatever the data.
- R9: A write to offset 0x0C4 with data bit 0 set sets event bit 28. With data bit 0 clear, the write has no effect.
- R10: A write to any other offset changes neither word, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (10) | Byte offset for read and write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| evt_pulse | input | 13 | Single-cycle event pulses, indexed by flag number |
| irq_line | output | 13 | Registered interrupt lines in fixed line order |

## Verification
Each flag is raised alone under a full mask, and the bench checks that exactly one line rises. This catches any swapped or shifted entry in the line order. Clears use alternating bit patterns so that clear-on-one is told apart from clear-all and from plain overwrite. A pulse that collides with a clear of the same flag tests which side wins. Mask writes are timed so that the bench tells apart the one-edge and two-edge latencies of the lines. The side-effect writes at 0x040 and 0x0C4, and writes to unmapped offsets, are each followed by reads of both words.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int NUM_FLAGS = 13;
    localparam int NUM_LINES = 13;

    // flag indices (event word bit = FLAG_LSB + index)
    localparam int F_UNDERRUN  = 0;
    localparam int F_RETRY_LIM = 1;
    localparam int F_LATE_COL  = 2;
    localparam int F_BUS_ERR   = 3;
    localparam int F_MGMT_DONE = 4;
    localparam int F_RX_BUF    = 5;
    localparam int F_RX_FRAME  = 6;
    localparam int F_TX_BUF    = 7;
    localparam int F_TX_FRAME  = 8;
    localparam int F_STOP_ACK  = 9;
    localparam int F_TX_BABBLE = 10;
    localparam int F_RX_BABBLE = 11;
    localparam int F_HEARTBEAT = 12;

    // register offsets
    localparam int unsigned OFF_EVENT = 'h004;
    localparam int unsigned OFF_MASK  = 'h008;
    localparam int unsigned OFF_MGMT  = 'h040;
    localparam int unsigned OFF_TCTL  = 'h0C4;
    localparam int STOP_REQ_BIT = 0;

    // which flag drives each interrupt line
    function automatic int unsigned line_src(input int unsigned line);
        case (line)
            0:       return F_TX_FRAME;
            1:       return F_TX_BUF;
            2:       return F_UNDERRUN;
            3:       return F_RETRY_LIM;
            4:       return F_RX_FRAME;
            5:       return F_RX_BUF;
            6:       return F_MGMT_DONE;
            7:       return F_LATE_COL;
            8:       return F_HEARTBEAT;
            9:       return F_STOP_ACK;
            10:      return F_BUS_ERR;
            11:      return F_TX_BABBLE;
            default: return F_RX_BABBLE;
        endcase
    endfunction
endpackage

// File: rtl/evt_flag_reg.sv
module evt_flag_reg #(
    parameter int NF = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flags_o
);
    typedef struct packed {
        logic [NF-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    // set takes priority over clear on the same bit
    always_comb begin
        st_d = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import evt_irq_pkg::*;
#(
    parameter int NF = NUM_FLAGS,
    parameter int NL = NUM_LINES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] active_i,
    output logic [NL-1:0] lines_o
);
    typedef struct packed {
        logic [NL-1:0] lines;
    } line_st_t;

    line_st_t      st_d, st_q;
    logic [NL-1:0] routed;

    for (genvar g = 0; g < NL; g++) begin : g_route
        assign routed[g] = active_i[line_src(g)];
    end

    always_comb begin
        st_d = st_q;
        st_d.lines = routed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lines_o = st_q.lines;
endmodule

// File: rtl/evt_irq_fanout.sv
module evt_irq_fanout
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_FLAGS-1:0] evt_pulse,
    output logic [NUM_LINES-1:0] irq_line
);
    localparam int FLAG_LSB = DATA_W - NUM_FLAGS;

    logic                 sel_event, sel_mask, sel_mgmt, sel_tctl;
    logic                 wr_event, wr_mask, wr_mgmt, wr_tctl;
    logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags_q, active;
    logic [DATA_W-1:0]    mask_q, evt_word;

    always_comb begin
        sel_event = (bus_addr == ADDR_W'(OFF_EVENT));
        sel_mask  = (bus_addr == ADDR_W'(OFF_MASK));
        sel_mgmt  = (bus_addr == ADDR_W'(OFF_MGMT));
        sel_tctl  = (bus_addr == ADDR_W'(OFF_TCTL));
        wr_event  = bus_wr && sel_event;
        wr_mask   = bus_wr && sel_mask;
        wr_mgmt   = bus_wr && sel_mgmt;
        wr_tctl   = bus_wr && sel_tctl && bus_wdata[STOP_REQ_BIT];
    end

    always_comb begin
        set_vec = evt_pulse;
        if (wr_mgmt) set_vec[F_MGMT_DONE] = 1'b1;
        if (wr_tctl) set_vec[F_STOP_ACK]  = 1'b1;
        clr_vec = wr_event ? bus_wdata[DATA_W-1:FLAG_LSB] : '0;
    end

    evt_flag_reg #(.NF(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (flags_q)
    );

    evt_mask_reg #(.W(DATA_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (bus_wdata),
        .mask_o  (mask_q)
    );

    assign evt_word = {flags_q, {FLAG_LSB{1'b0}}};
    assign active   = flags_q & mask_q[DATA_W-1:FLAG_LSB];

    irq_line_map #(.NF(NUM_FLAGS), .NL(NUM_LINES)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .lines_o  (irq_line)
    );

    always_comb begin
        if (sel_event)     bus_rdata = evt_word;
        else if (sel_mask) bus_rdata = mask_q;
        else               bus_rdata = '0;
    end
endmodule

// File: rtl/evt_irq_fanout_chk.sv
module evt_irq_fanout_chk
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [NUM_FLAGS-1:0] evt_pulse,
    input logic [NUM_LINES-1:0] irq_line,
    input logic [DATA_W-1:0]    evt_word,
    input logic [DATA_W-1:0]    mask_word
);
    localparam int LSB = DATA_W - NUM_FLAGS;

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_line == '0 && evt_word == '0 && mask_word == '0));

    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != '0) |=>
        ((evt_word[DATA_W-1:LSB] & $past(evt_pulse)) == $past(evt_pulse)));

    p_clear_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EVENT) && evt_pulse == '0) |=>
        ((evt_word & $past(bus_wdata)) == '0));

    p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_MASK)) |=> (mask_word == $past(bus_wdata)));

    p_line_txf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_line[0] == $past(evt_word[LSB+F_TX_FRAME] && mask_word[LSB+F_TX_FRAME])));

    p_line_hb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_line[8] == $past(evt_word[LSB+F_HEARTBEAT] && mask_word[LSB+F_HEARTBEAT])));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_EVENT) && evt_pulse != '0) |=>
        ((evt_word[DATA_W-1:LSB] & $past(evt_pulse)) == $past(evt_pulse)));

    p_mgmt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_MGMT)) |=> evt_word[LSB+F_MGMT_DONE]);

    p_stop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFF_TCTL) && bus_wdata[STOP_REQ_BIT]) |=> evt_word[LSB+F_STOP_ACK]);
endmodule

bind evt_irq_fanout evt_irq_fanout_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_pulse (evt_pulse),
    .irq_line  (irq_line),
    .evt_word  (evt_word),
    .mask_word (mask_q)
);

// File: tb/evt_irq_fanout_bench.sv
module evt_irq_fanout_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [12:0] pulse = '0;
    logic [31:0] rdata;
    logic [12:0] irq;

    int total = 0;
    int bad = 0;
    bit armed = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_evt, m_mask, m_act, m_clr, m_set;
    logic [12:0] m_irq;
    int line_pos [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

    evt_irq_fanout u_evt_irq_fanout (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .evt_pulse(pulse), .irq_line(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [9:0] a);
        if (a == 10'h004) return m_evt;
        if (a == 10'h008) return m_mask;
        return 32'h0;
    endfunction

    // reference model plus per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            m_evt = '0; m_mask = '0; m_irq = '0;
        end else begin
            m_act = m_evt & m_mask;
            for (int k = 0; k < 13; k++) m_irq[k] = m_act[line_pos[k]];
            m_clr = (wr && addr == 10'h004) ? wdata : 32'h0;
            m_set = {pulse, 19'h0};
            if (wr && addr == 10'h040) m_set[23] = 1'b1;
            if (wr && addr == 10'h0C4 && wdata[0]) m_set[28] = 1'b1;
            if (wr && addr == 10'h008) m_mask = wdata;
            m_evt = ((m_evt & ~m_clr) | m_set) & 32'hFFF8_0000;
        end
        #5;
        if (armed) begin
            check("R6 lines vs model", {19'h0, irq}, {19'h0, m_irq});
            check("R5 read vs model", rdata, m_read(addr));
        end
    end

    task automatic op(input logic [9:0] a, input logic [31:0] d, input logic [12:0] p, input logic w);
        @(negedge clk);
        wr = w; addr = a; wdata = d; pulse = p;
        @(negedge clk);
        wr = 0; pulse = '0;
    endtask

    task automatic peek(input logic [9:0] a);
        addr = a;
        @(posedge clk); #5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        // R1
        peek(10'h004); check("R1 event after reset", rdata, 32'h0);
        check("R1 lines after reset", {19'h0, irq}, 32'h0);
        peek(10'h008); check("R1 mask after reset", rdata, 32'h0);

        // R4
        op(10'h008, 32'hFFFF_FFFF, '0, 1);
        peek(10'h008); check("R4 mask full", rdata, 32'hFFFF_FFFF);

        // R2 and R6: each flag alone lights exactly one line
        for (int f = 0; f < 13; f++) begin
            op(10'h000, 32'h0, 13'(1 << f), 0);
            peek(10'h004); check("R2 flag set", rdata, 32'(1) << (19 + f));
            for (int k = 0; k < 13; k++)
                if (line_pos[k] == 19 + f) check("R6 single line", {19'h0, irq}, 32'(1) << k);
            op(10'h004, 32'hFFFF_FFFF, '0, 1);
            peek(10'h004); check("R3 clear all", rdata, 32'h0);
        end

        // R3 partial clear
        op(10'h000, 32'h0, 13'h1FFF, 0);
        op(10'h004, 32'hAAAA_0000, '0, 1);
        peek(10'h004); check("R3 clear ones only", rdata, 32'h5550_0000 & 32'hFFF8_0000 | 32'h0008_0000 & ~32'hAAAA_0000);
        check("R5 low bits zero", rdata & 32'h0007_FFFF, 32'h0);

        // R6 latency after mask change
        @(negedge clk); wr = 1; addr = 10'h008; wdata = 32'h0;
        @(negedge clk); wr = 0;
        // one edge after the write edge the mask is zero but lines still reflect old state
        check("R6 lines hold one edge", {19'h0, irq}, {19'h0, m_irq});
        @(posedge clk); #5;
        check("R6 lines drop second edge", {19'h0, irq}, 32'h0);
        op(10'h008, 32'hFFFF_FFFF, '0, 1);
        op(10'h004, 32'hFFFF_FFFF, '0, 1);

        // R7 collision
        op(10'h004, 32'hFFFF_FFFF, 13'h0008, 1);
        peek(10'h004); check("R7 set wins over clear", rdata, 32'h0040_0000);
        op(10'h004, 32'hFFFF_FFFF, '0, 1);

        // R8
        op(10'h040, 32'h0, '0, 1);
        peek(10'h004); check("R8 mgmt write sets bit 23", rdata, 32'h0080_0000);
        op(10'h004, 32'hFFFF_FFFF, '0, 1);

        // R9
        op(10'h0C4, 32'hFFFF_FFFE, '0, 1);
        peek(10'h004); check("R9 bit0 clear no effect", rdata, 32'h0);
        op(10'h0C4, 32'h1, '0, 1);
        peek(10'h004); check("R9 stop request sets bit 28", rdata, 32'h1000_0000);

        // R10
        op(10'h100, 32'hFFFF_FFFF, '0, 1);
        peek(10'h100); check("R10 unmapped reads zero", rdata, 32'h0);
        peek(10'h004); check("R10 event unchanged", rdata, 32'h1000_0000);
        peek(10'h008); check("R10 mask unchanged", rdata, 32'hFFFF_FFFF);

        repeat (3) @(posedge clk);
        #6;
        armed = 0;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule